// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked host and an external 128K x 16 asynchronous static RAM. The host offers one word access at a time through a request/ready handshake, with a 17-bit word address, 16-bit write data and two byte enables. Read data comes back with a one-cycle valid pulse. On the memory side the controller drives the address, a select pair of opposite polarity, output enable, write enable and one strobe per byte lane. The data bus is split into an outgoing word, an incoming word and a drive enable, which a pad wrapper turns into a bidirectional port.

Memory timing is met by counting clock cycles. Every nanosecond minimum or maximum is a parameter, and the controller rounds it up to whole cycles of the clock-period parameter. A write has one set-up cycle with write enable high, then a write-enable pulse, then one hold cycle. The write ends on the rising edge of write enable, and the data and strobes stay in place for the hold cycle that follows. A read holds output enable low for the longest access time and then captures the enabled byte lanes.

Between accesses the controller deselects the memory and raises every byte strobe, which leaves the device in standby. A request with no byte enabled completes at once and never touches the memory.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: During reset, and whenever `host_ready` is high, the memory is parked: `mem_cs_n`=1, `mem_cs`=0, `mem_we_n`=1, `mem_oe_n`=1, all `mem_bs_n` bits 1, and `mem_dq_oe`=0.
- R2: A request is accepted on the clock edge where `host_req` and `host_ready` are both high. With at least one byte enabled, `host_ready` then stays low for exactly 2+WP cycles for a write and RD cycles for a read, and then returns high.
- R3: A write runs as follows: one cycle selected with `mem_we_n`=1, then WP cycles with `mem_we_n`=0, then one hold cycle with `mem_we_n`=1. Through the hold cycle the memory stays selected and `mem_dq_oe` stays 1.
- R4: Whenever `mem_we_n` is 0, `mem_oe_n` is 1 and `mem_dq_oe` is 1. `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R5: `host_be` bit 0 controls data bits 7:0 through `mem_bs_n[0]`, and bit 1 controls bits 15:8 through `mem_bs_n[1]`. A strobe is low (0) during an access exactly when its enable bit is 1, so only the enabled bytes of a word are written.
- R6: A read holds `mem_oe_n`=0 with the memory selected for RD cycles. In the cycle after that, `host_rvalid` is 1 for exactly one cycle. `host_rdata` then carries the memory data in enabled lanes and zero in disabled lanes.
- R7: While the memory is selected, `mem_addr` equals the accepted request address and `mem_bs_n` does not change.
- R8: A request with `host_be`=0 is accepted without selecting the memory or pulsing write or output enable, and `host_ready` stays high. For a read, `host_rvalid` is 1 in the next cycle with `host_rdata`=0.
- R9: WP is the largest of ceil(T_WP/T_CLK), ceil(T_SD/T_CLK), ceil(T_AW/T_CLK)-1, ceil(T_WC/T_CLK)-2 and 1. RD is the largest of the ceilings of T_RC, T_AA, T_ACS, T_OE and T_BA over T_CLK, and at least 1. With the defaults (20 ns clock, 45 ns grade), WP=2 and RD=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host request, held until accepted |
| host_ready | output | 1 | Controller idle and able to accept |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte enables, bit 0 = low byte |
| host_rdata | output | 16 | Read data, disabled lanes zero |
| host_rvalid | output | 1 | One-cycle read completion pulse |
| mem_addr | output | 17 | Memory address |
| mem_cs_n | output | 1 | Active-low select |
| mem_cs | output | 1 | Active-high select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_bs_n | output | 2 | Active-low byte strobes, bit 0 = low byte |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_in | input | 16 | Data returned by memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |

## Verification
The assertions assume that the host holds `host_req` and its fields steady until the request is accepted. They also assume that `mem_dq_in` is settled by the cycle in which the read is captured. The stimulus drives host fields only at falling edges. It raises a request only while `host_ready` is seen high and lowers it right after acceptance. A behavioural memory in the bench answers combinationally while it is selected with output enable low, and it drives a filler pattern on lanes whose strobe is high, so a failure to mask those lanes shows up in the read data.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared phase type and cycle-rounding helpers for the SRAM strobe controller.
// Assumes all timing values are non-negative whole nanoseconds.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_WSETUP = 3'd1,
        PH_WPULSE = 3'd2,
        PH_WHOLD  = 3'd3,
        PH_RACC   = 3'd4
    } phase_t;

    // Round a nanosecond interval up to whole clock cycles.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Subtraction clipped at zero.
    function automatic int unsigned usub(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : 0;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Module: loadable down-counter that times one phase of a memory access.
// Assumes: load has priority; the count stops at zero and flags expiry there.
module sram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new phase length or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_phase_seq.sv
// Module: access sequencer. Accepts host requests, steps through write and read phases,
// and decodes select, output-enable and write-enable strobes from the phase.
// Assumes: host fields are stable while host_req is high and host_ready is high.
module sram_phase_seq
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int LANES  = 2,
    parameter int WP_CYC = 2,
    parameter int RD_CYC = 3,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [LANES-1:0]  host_be,
    input  logic              tmr_expired,
    output phase_t            phase,
    output logic              host_ready,
    output logic              accept,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              rd_capture,
    output logic              zero_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_oe_n,
    output logic              mem_we_n
);

    localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);

    phase_t            phase_q;
    phase_t            phase_d;
    logic [ADDR_W-1:0] addr_q;
    logic              any_byte;

    assign any_byte   = |host_be;
    assign host_ready = (phase_q == PH_IDLE);
    assign accept     = host_req && host_ready;
    assign zero_rd    = accept && !host_we && !any_byte;
    assign rd_capture = (phase_q == PH_RACC) && tmr_expired;
    assign phase      = phase_q;

    // Next-phase choice and timer loading.
    always_comb begin
        phase_d  = phase_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (phase_q)
            PH_IDLE: begin
                if (accept && any_byte) begin
                    if (host_we) begin
                        phase_d = PH_WSETUP;
                    end else begin
                        phase_d  = PH_RACC;
                        tmr_load = 1'b1;
                        tmr_val  = RD_LOAD;
                    end
                end
            end
            PH_WSETUP: begin
                phase_d  = PH_WPULSE;
                tmr_load = 1'b1;
                tmr_val  = WP_LOAD;
            end
            PH_WPULSE: begin
                if (tmr_expired) begin
                    phase_d = PH_WHOLD;
                end
            end
            PH_WHOLD: begin
                phase_d = PH_IDLE;
            end
            PH_RACC: begin
                if (tmr_expired) begin
                    phase_d = PH_IDLE;
                end
            end
            default: begin
                phase_d = PH_IDLE;
            end
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Address latch, loaded on every accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (accept) begin
            addr_q <= host_addr;
        end
    end

    assign mem_addr = addr_q;
    assign mem_cs_n = (phase_q == PH_IDLE);
    assign mem_cs   = (phase_q != PH_IDLE);
    assign mem_oe_n = (phase_q != PH_RACC);
    assign mem_we_n = (phase_q != PH_WPULSE);

endmodule

// File: rtl/sram_byte_lanes.sv
// Module: per-byte data path. Latches write data and byte enables, drives the byte
// strobes, and captures read data with disabled lanes forced to zero.
// Assumes: DATA_W is LANES bytes; accept, rd_capture and zero_rd come from the sequencer.
module sram_byte_lanes
    import sram_ctrl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [LANES-1:0]  host_be,
    input  phase_t            phase,
    input  logic              rd_capture,
    input  logic              zero_rd,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [LANES-1:0]  mem_bs_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid
);

    logic active;
    logic rvalid_q;

    assign active    = (phase != PH_IDLE);
    assign mem_dq_oe = (phase == PH_WPULSE) || (phase == PH_WHOLD);

    // Read completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_capture || zero_rd;
        end
    end

    assign host_rvalid = rvalid_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] wd_q;
        logic       be_q;
        logic [7:0] rd_q;

        // Latch this lane's write byte and enable at acceptance.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wd_q <= '0;
                be_q <= 1'b0;
            end else if (accept) begin
                wd_q <= host_wdata[g*8 +: 8];
                be_q <= host_be[g];
            end
        end

        // Capture this lane's read byte, or zero when the lane is disabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_q <= '0;
            end else if (zero_rd) begin
                rd_q <= '0;
            end else if (rd_capture) begin
                rd_q <= be_q ? mem_dq_in[g*8 +: 8] : 8'h00;
            end
        end

        assign mem_bs_n[g]          = !(active && be_q);
        assign mem_dq_out[g*8 +: 8] = wd_q;
        assign host_rdata[g*8 +: 8] = rd_q;
    end

endmodule

// File: rtl/sram_strobe_ctrl.sv
// Module: top of the asynchronous SRAM strobe controller. Converts single-word host
// requests into cycle-counted select, enable and byte-strobe sequences.
// Assumes: one outstanding request; timing parameters in ns, rounded up to cycles.
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 16,
    parameter int CLK_NS   = 20,
    parameter int T_WC_NS  = 45,
    parameter int T_WP_NS  = 35,
    parameter int T_AW_NS  = 35,
    parameter int T_SD_NS  = 20,
    parameter int T_RC_NS  = 45,
    parameter int T_AA_NS  = 45,
    parameter int T_ACS_NS = 45,
    parameter int T_OE_NS  = 20,
    parameter int T_BA_NS  = 45
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    output logic              host_ready,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W/8-1:0] host_be,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W/8-1:0] mem_bs_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);

    localparam int LANES = DATA_W / 8;

    localparam int unsigned WP_A = umax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS));
    localparam int unsigned WP_B = umax(usub(ns_to_cyc(T_AW_NS, CLK_NS), 1),
                                        usub(ns_to_cyc(T_WC_NS, CLK_NS), 2));
    localparam int WP_CYC = int'(umax(umax(WP_A, WP_B), 1));

    localparam int unsigned RD_A = umax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS));
    localparam int unsigned RD_B = umax(ns_to_cyc(T_ACS_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS));
    localparam int RD_CYC = int'(umax(umax(RD_A, RD_B), umax(ns_to_cyc(T_BA_NS, CLK_NS), 1)));

    localparam int CNT_W = $clog2(int'(umax(WP_CYC, RD_CYC)) + 1);

    phase_t           phase;
    logic             accept;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             rd_capture;
    logic             zero_rd;

    sram_phase_seq #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .WP_CYC (WP_CYC),
        .RD_CYC (RD_CYC),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_req    (host_req),
        .host_we     (host_we),
        .host_addr   (host_addr),
        .host_be     (host_be),
        .tmr_expired (tmr_expired),
        .phase       (phase),
        .host_ready  (host_ready),
        .accept      (accept),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .rd_capture  (rd_capture),
        .zero_rd     (zero_rd),
        .mem_addr    (mem_addr),
        .mem_cs_n    (mem_cs_n),
        .mem_cs      (mem_cs),
        .mem_oe_n    (mem_oe_n),
        .mem_we_n    (mem_we_n)
    );

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_byte_lanes #(
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_lanes (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .host_wdata  (host_wdata),
        .host_be     (host_be),
        .phase       (phase),
        .rd_capture  (rd_capture),
        .zero_rd     (zero_rd),
        .mem_dq_in   (mem_dq_in),
        .mem_bs_n    (mem_bs_n),
        .mem_dq_out  (mem_dq_out),
        .mem_dq_oe   (mem_dq_oe),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid)
    );

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
// Module: protocol checker for the SRAM strobe controller, attached by bind.
// Assumes: WP_MIN equals the controller's derived write-pulse length.
module sram_strobe_ctrl_chk #(
    parameter int ADDR_W = 17,
    parameter int LANES  = 2,
    parameter int WP_MIN = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_req,
    input logic              host_ready,
    input logic [LANES-1:0]  host_be,
    input logic              host_rvalid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_cs,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [LANES-1:0]  mem_bs_n,
    input logic              mem_dq_oe
);

    logic [15:0] we_run;

    // Count consecutive sampled cycles with write enable low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_run <= '0;
        end else if (!mem_we_n) begin
            we_run <= we_run + 1'b1;
        end else begin
            we_run <= '0;
        end
    end

    p_park_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (mem_cs_n && !mem_cs && (&mem_bs_n) && mem_we_n && mem_oe_n && !mem_dq_oe));

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_ready && (|host_be)) |=> !host_ready);

    p_hold_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && !mem_cs_n && $stable(mem_bs_n)));

    p_no_bus_fight_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && mem_dq_oe));

    p_drive_only_oe_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    p_rvalid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);

    p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_bs_n)));

    p_we_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run >= 16'(WP_MIN)));

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .LANES  (DATA_W / 8),
    .WP_MIN (WP_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_req    (host_req),
    .host_ready  (host_ready),
    .host_be     (host_be),
    .host_rvalid (host_rvalid),
    .mem_addr    (mem_addr),
    .mem_cs_n    (mem_cs_n),
    .mem_cs      (mem_cs),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_bs_n    (mem_bs_n),
    .mem_dq_oe   (mem_dq_oe)
);

// File: tb/test_sram_strobe_ctrl.sv
// Bench: random and directed word accesses against a behavioural SRAM model.
module test_sram_strobe_ctrl;

    localparam int WP_EXP = 2;   // R9 with 20 ns clock: max(2,1,1,1)
    localparam int RD_EXP = 3;   // R9 with 20 ns clock: ceil(45/20)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_ready;
    logic        host_we = 1'b0;
    logic [16:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  host_be = '0;
    logic [15:0] host_rdata;
    logic        host_rvalid;
    logic [16:0] mem_addr;
    logic        mem_cs_n;
    logic        mem_cs;
    logic        mem_oe_n;
    logic        mem_we_n;
    logic [1:0]  mem_bs_n;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in;
    logic        mem_dq_oe;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;
    logic mon_en = 1'b0;

    logic [15:0] model [0:255];
    logic [15:0] expect_mem [0:255];
    logic [16:0] cur_addr = '0;
    logic [1:0]  cur_be = '0;
    int sel_cycles = 0;
    int we_run = 0;
    int oe_run = 0;

    always #10 clk = ~clk;   // 50 MHz

    sram_strobe_ctrl i_sram_strobe_ctrl (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_ready(host_ready),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_bs_n(mem_bs_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    // Behavioural memory read path: filler on lanes whose strobe is high.
    always_comb begin
        logic rd_sel;
        rd_sel = !mem_cs_n && mem_cs && !mem_oe_n && mem_we_n;
        mem_dq_in[7:0]  = (rd_sel && !mem_bs_n[0]) ? model[mem_addr[7:0]][7:0]  : 8'hC3;
        mem_dq_in[15:8] = (rd_sel && !mem_bs_n[1]) ? model[mem_addr[7:0]][15:8] : 8'h3C;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    // Monitor: write storage in the model plus per-cycle strobe rules.
    always @(negedge clk) begin
        if (mon_en) begin
            if (!mem_cs_n) begin
                sel_cycles++;
                check(mem_addr == cur_addr, "R7 address", int'(mem_addr), int'(cur_addr));
                check(mem_bs_n == ~cur_be, "R5 strobes", int'(mem_bs_n), int'(~cur_be));
            end
            if (host_ready) begin
                check(mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && (&mem_bs_n) && !mem_dq_oe,
                      "R1 park", {mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_bs_n, mem_dq_oe}, 7'b1011110);
            end
            if (!mem_we_n) begin
                we_run++;
                check(mem_oe_n && mem_dq_oe, "R4 write drive", {mem_oe_n, mem_dq_oe}, 2'b11);
            end else if (we_run > 0) begin
                check(we_run == WP_EXP, "R9 we width", we_run, WP_EXP);
                check(mem_dq_oe && !mem_cs_n, "R3 hold cycle", {mem_dq_oe, mem_cs_n}, 2'b10);
                if (!mem_bs_n[0]) model[mem_addr[7:0]][7:0]  = mem_dq_out[7:0];
                if (!mem_bs_n[1]) model[mem_addr[7:0]][15:8] = mem_dq_out[15:8];
                we_run = 0;
            end
            if (!mem_oe_n) begin
                oe_run++;
                check(!mem_dq_oe, "R4 no fight", int'(mem_dq_oe), 0);
            end else if (oe_run > 0) begin
                check(oe_run == RD_EXP, "R9 oe width", oe_run, RD_EXP);
                oe_run = 0;
            end
        end
    end

    task automatic issue(input logic we, input logic [16:0] a, input logic [15:0] d, input logic [1:0] be,
                         output int busy);
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d; host_be = be;
        cur_addr = a; cur_be = be;
        @(negedge clk);
        host_req = 1'b0;
        busy = 0;
        while (!host_ready) begin
            busy++;
            @(negedge clk);
        end
    endtask

    task automatic do_write(input logic [16:0] a, input logic [15:0] d, input logic [1:0] be);
        int busy;
        int sel0;
        sel0 = sel_cycles;
        issue(1'b1, a, d, be, busy);
        if (be != 2'b00) begin
            check(busy == WP_EXP + 2, "R2 write busy", busy, WP_EXP + 2);
            expect_mem[a[7:0]] = (expect_mem[a[7:0]] & ~lane_mask(be)) | (d & lane_mask(be));
        end else begin
            check(busy == 0 && sel_cycles == sel0, "R8 empty write", sel_cycles - sel0 + busy, 0);
        end
    endtask

    task automatic do_read(input logic [16:0] a, input logic [1:0] be);
        int busy;
        int sel0;
        logic [15:0] exp;
        sel0 = sel_cycles;
        issue(1'b0, a, 16'h0, be, busy);
        exp = expect_mem[a[7:0]] & lane_mask(be);
        if (be != 2'b00) begin
            check(busy == RD_EXP, "R2 read busy", busy, RD_EXP);
            check(host_rvalid == 1'b1, "R6 rvalid", int'(host_rvalid), 1);
            check(host_rdata == exp, "R6 rdata", int'(host_rdata), int'(exp));
        end else begin
            check(busy == 0 && sel_cycles == sel0, "R8 empty read no access", sel_cycles - sel0 + busy, 0);
            check(host_rvalid && host_rdata == 16'h0, "R8 empty read data", int'({host_rvalid, host_rdata}), 17'h10000);
        end
        @(negedge clk);
        check(!host_rvalid, "R6 single pulse", int'(host_rvalid), 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            model[i] = 16'h0;
            expect_mem[i] = 16'h0;
        end
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check(mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && (&mem_bs_n) && !mem_dq_oe && !host_rvalid,
              "R1 reset", {mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_bs_n, mem_dq_oe}, 7'b1011110);
        rst_n = 1'b1;
        @(negedge clk);
        check(host_ready, "R2 ready after reset", int'(host_ready), 1);
        mon_en = 1'b1;

        // Directed: full word, each lane alone, boundaries of the address space.
        do_write(17'h00000, 16'hA1B2, 2'b11);
        do_read (17'h00000, 2'b11);
        do_write(17'h1FFFF, 16'h1234, 2'b11);
        do_write(17'h1FFFF, 16'hFF77, 2'b01);   // R5 low lane only
        do_read (17'h1FFFF, 2'b11);
        do_write(17'h1FFFF, 16'h99EE, 2'b10);   // R5 high lane only
        do_read (17'h1FFFF, 2'b11);
        do_read (17'h1FFFF, 2'b01);             // R6 upper lane masked
        do_read (17'h1FFFF, 2'b10);             // R6 lower lane masked
        do_write(17'h00000, 16'h5555, 2'b00);   // R8 no effect
        do_read (17'h00000, 2'b11);
        do_read (17'h00000, 2'b00);             // R8 empty read

        // Random mix.
        for (int n = 0; n < 300; n++) begin
            logic [16:0] a;
            logic [1:0]  be;
            a  = 17'($urandom);
            be = 2'($urandom);
            if ($urandom_range(0, 1) == 0)
                do_write(a, 16'($urandom), be);
            else
                do_read(a, be);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule